// File: doc/BRIEF.md
# Sized Operand Mover

This block carries operands between a byte-wide, big-endian memory and two register banks: one of data registers and one of address registers, each eight entries of 32 bits. A request names a direction (fetch or store), an operand size (byte, word or long), a location space (data bank, address bank or memory), a register number and a byte address. Fetched operands come back narrowed to their size and, on request, sign-extended to 32 bits. Register stores overwrite only the low part of the target register that matches the size. Memory stores are not performed at once. They are parked in a small pending-write queue, and a later commit strobe writes the whole queue to memory in arrival order.

The memory is a synchronous RAM with one byte per access and a read latency of one cycle. Every memory address is reduced modulo the configured memory size, and a multi-byte access that runs past the last byte continues at byte 0. While a memory fetch or a drain is in progress the block reports busy and ignores new requests. Each accepted request yields exactly one response, which carries a result and an error flag.

Top module: `opnd_mover`

## Requirements
- R1: After reset all registers of both banks read 0, the pending count is 0, and busy and rsp_valid are low.
- R2: Size code 3 or space code 3 gives a response with rsp_err=1 and changes no register, no pending entry and no memory byte. The size codes are 0 byte, 1 word and 2 long. The space codes are 0 data bank, 1 address bank and 2 memory.
- R3: A register fetch with req_sext=0 returns bits 7..0 for a byte, bits 15..0 for a word and all 32 bits for a long, with the upper bits zero. The response arrives in the cycle after acceptance.
- R4: A fetch with req_sext=1 copies bit 7 (byte) or bit 15 (word) into all upper bits of the result. A long is returned unchanged.
- R5: A register store of a byte replaces bits 7..0 and keeps bits 31..8. A word store replaces bits 15..0 and keeps bits 31..16. A long store replaces the whole register.
- R6: A memory fetch reads 1, 2 or 4 consecutive bytes. The byte at the lowest address becomes the most significant byte of the result.
- R7: The byte address is req_addr modulo MEM_BYTES, and the byte that follows address MEM_BYTES-1 is address 0.
- R8: A memory store records address, size and size-masked value in the next free pending slot and raises pend_count by one. Memory is not written before a commit, so a fetch before the commit returns the old bytes.
- R9: A commit writes every pending entry to memory, oldest first, as its size in bytes big-endian. The block then clears the queue, so a later entry to the same byte wins.
- R10: A memory store while PEND_DEPTH entries are pending gives rsp_err=1 and is dropped, and pend_count stays unchanged.
- R11: A commit with an empty queue writes nothing and does not raise busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present (taken when busy is low and commit is low) |
| req_store | input | 1 | 1 = store, 0 = fetch |
| req_size | input | 2 | 0 byte, 1 word, 2 long, 3 invalid |
| req_sext | input | 1 | Sign-extend fetched byte or word |
| req_space | input | 2 | 0 data bank, 1 address bank, 2 memory, 3 invalid |
| req_reg | input | RSEL_W | Register number within the bank |
| req_addr | input | 32 | Memory byte address before modulo reduction |
| req_wdata | input | 32 | Store value |
| commit | input | 1 | Drain the pending queue to memory |
| busy | output | 1 | Memory fetch or drain in progress |
| rsp_valid | output | 1 | Response strobe |
| rsp_data | output | 32 | Fetched operand (0 for stores and errors) |
| rsp_err | output | 1 | Invalid request or queue overflow |
| pend_count | output | CNT_W | Number of pending memory writes |
| mem_en | output | 1 | RAM access enable |
| mem_we | output | 1 | RAM write enable |
| mem_addr | output | MEM_AW | RAM byte address |
| mem_wdata | output | 8 | RAM write byte |
| mem_rdata | input | 8 | RAM read byte, one cycle after the address |

## Verification
Register traffic uses values whose sign bit is set at bit 7, at bit 15, or at neither. This separates zero-extension from sign-extension and shows whether a narrow store keeps or clobbers the upper bits. Memory fetches are placed mid-array, across the top of the array and at addresses above MEM_BYTES, which exposes byte-order and wrap errors. Store sequences fill the queue, overflow it and hit one byte twice, so that drain order, masking and deferral each show up in the memory image.

// File: rtl/opnd_pkg.sv
package opnd_pkg;

    typedef enum logic [1:0] {SZ_B = 2'd0, SZ_W = 2'd1, SZ_L = 2'd2, SZ_BAD = 2'd3} size_e;
    typedef enum logic [1:0] {SP_DREG = 2'd0, SP_AREG = 2'd1, SP_MEM = 2'd2, SP_BAD = 2'd3} space_e;
    typedef enum logic [1:0] {PH_IDLE = 2'd0, PH_READ = 2'd1, PH_DRAIN = 2'd2} phase_e;

    function automatic logic [2:0] size_bytes(size_e sz);
        case (sz)
            SZ_B:    return 3'd1;
            SZ_W:    return 3'd2;
            SZ_L:    return 3'd4;
            default: return 3'd0;
        endcase
    endfunction

    function automatic logic [31:0] size_mask(size_e sz);
        case (sz)
            SZ_B:    return 32'h0000_00FF;
            SZ_W:    return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic logic [31:0] narrow(logic [31:0] v, size_e sz, logic sx);
        case (sz)
            SZ_B:    return {{24{sx & v[7]}}, v[7:0]};
            SZ_W:    return {{16{sx & v[15]}}, v[15:0]};
            default: return v;
        endcase
    endfunction

    function automatic logic [31:0] merge(logic [31:0] old, logic [31:0] nv, size_e sz);
        return (old & ~size_mask(sz)) | (nv & size_mask(sz));
    endfunction

endpackage

// File: rtl/opnd_regbank.sv
module opnd_regbank import opnd_pkg::*; #(
    parameter int NREG  = 8,
    parameter int SEL_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [SEL_W-1:0] sel,
    input  size_e            size,
    input  logic [31:0]      wdata,
    output logic [31:0]      rdata
);
    logic [31:0] regs_q [NREG];
    logic [31:0] regs_d [NREG];

    assign rdata = regs_q[sel];

    always_comb begin
        for (int i = 0; i < NREG; i++) begin
            regs_d[i] = regs_q[i];
            if (we && SEL_W'(i) == sel) regs_d[i] = merge(regs_q[i], wdata, size);
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NREG; i++) begin
            if (!rst_n) regs_q[i] <= '0;
            else        regs_q[i] <= regs_d[i];
        end
    end
endmodule

// File: rtl/opnd_pendq.sv
module opnd_pendq import opnd_pkg::*; #(
    parameter int DEPTH = 4,
    parameter int AW    = 10,
    parameter int IDX_W = 2,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [AW-1:0]    push_addr,
    input  size_e            push_size,
    input  logic [31:0]      push_val,
    input  logic             clear,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [AW-1:0]    rd_addr,
    output size_e            rd_size,
    output logic [31:0]      rd_val,
    output logic [CNT_W-1:0] count,
    output logic             full
);
    logic [AW-1:0]    addr_q [DEPTH];
    size_e            size_q [DEPTH];
    logic [31:0]      val_q  [DEPTH];
    logic [CNT_W-1:0] count_q, count_d;

    assign rd_addr = addr_q[rd_idx];
    assign rd_size = size_q[rd_idx];
    assign rd_val  = val_q[rd_idx];
    assign count   = count_q;
    assign full    = (count_q == CNT_W'(DEPTH));

    always_comb begin
        count_d = count_q;
        if (clear)             count_d = '0;
        else if (push && !full) count_d = count_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                addr_q[i] <= '0;
                size_q[i] <= SZ_B;
                val_q[i]  <= '0;
            end
        end else begin
            count_q <= count_d;
            for (int i = 0; i < DEPTH; i++) begin
                if (push && !full && CNT_W'(i) == count_q) begin
                    addr_q[i] <= push_addr;
                    size_q[i] <= push_size;
                    val_q[i]  <= push_val;
                end
            end
        end
    end
endmodule

// File: rtl/opnd_mover.sv
module opnd_mover import opnd_pkg::*; #(
    parameter int MEM_BYTES  = 1000,
    parameter int PEND_DEPTH = 4,
    parameter int NREG       = 8,
    parameter int MEM_AW     = $clog2(MEM_BYTES),
    parameter int CNT_W      = $clog2(PEND_DEPTH + 1),
    parameter int RSEL_W     = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_store,
    input  logic [1:0]        req_size,
    input  logic              req_sext,
    input  logic [1:0]        req_space,
    input  logic [RSEL_W-1:0] req_reg,
    input  logic [31:0]       req_addr,
    input  logic [31:0]       req_wdata,
    input  logic              commit,
    output logic              busy,
    output logic              rsp_valid,
    output logic [31:0]       rsp_data,
    output logic              rsp_err,
    output logic [CNT_W-1:0]  pend_count,
    output logic              mem_en,
    output logic              mem_we,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata
);
    localparam int IDX_W = (PEND_DEPTH > 1) ? $clog2(PEND_DEPTH) : 1;

    typedef struct packed {
        phase_e            phase;
        logic [2:0]        nbytes;
        logic [2:0]        issued;
        logic [2:0]        got;
        logic              pend;
        logic [MEM_AW-1:0] addr;
        logic [31:0]       acc;
        size_e             size;
        logic              sext;
        logic [IDX_W-1:0]  ent;
        logic [1:0]        bidx;
        logic              rsp_valid;
        logic [31:0]       rsp_data;
        logic              rsp_err;
    } state_t;

    state_t st_q, st_d;

    size_e             sz;
    space_e            sp;
    logic              req_bad;
    logic [MEM_AW-1:0] req_mod;
    logic [1:0]        bank_we;
    logic [31:0]       bank_rdata [2];
    logic              push, clear;
    logic [MEM_AW-1:0] pq_addr;
    size_e             pq_size;
    logic [31:0]       pq_val;
    logic [CNT_W-1:0]  pq_count;
    logic              pq_full;
    logic [2:0]        pq_n;
    logic [MEM_AW:0]   dsum;
    logic [MEM_AW-1:0] drain_addr;
    logic [1:0]        dpos;
    logic [7:0]        drain_byte;

    function automatic logic [MEM_AW-1:0] wrap_inc(logic [MEM_AW-1:0] a);
        return (a == MEM_AW'(MEM_BYTES - 1)) ? '0 : a + 1'b1;
    endfunction

    assign sz      = size_e'(req_size);
    assign sp      = space_e'(req_space);
    assign req_bad = (sz == SZ_BAD) || (sp == SP_BAD);
    assign req_mod = MEM_AW'(req_addr % 32'(MEM_BYTES));

    for (genvar b = 0; b < 2; b++) begin : g_bank
        opnd_regbank #(.NREG(NREG), .SEL_W(RSEL_W)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (bank_we[b]),
            .sel   (req_reg),
            .size  (sz),
            .wdata (req_wdata),
            .rdata (bank_rdata[b])
        );
    end

    opnd_pendq #(.DEPTH(PEND_DEPTH), .AW(MEM_AW), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_addr (req_mod),
        .push_size (sz),
        .push_val  (req_wdata & size_mask(sz)),
        .clear     (clear),
        .rd_idx    (st_q.ent),
        .rd_addr   (pq_addr),
        .rd_size   (pq_size),
        .rd_val    (pq_val),
        .count     (pq_count),
        .full      (pq_full)
    );

    // drain byte address and big-endian byte lane of the current entry
    always_comb begin
        pq_n = size_bytes(pq_size);
        dsum = {1'b0, pq_addr} + (MEM_AW + 1)'(st_q.bidx);
        if (dsum >= (MEM_AW + 1)'(MEM_BYTES)) dsum = dsum - (MEM_AW + 1)'(MEM_BYTES);
        drain_addr = dsum[MEM_AW-1:0];
        dpos       = 2'(pq_n - 3'd1 - 3'(st_q.bidx));
        drain_byte = 8'(pq_val >> {dpos, 3'b000});
    end

    always_comb begin
        st_d           = st_q;
        st_d.rsp_valid = 1'b0;
        st_d.rsp_err   = 1'b0;
        st_d.rsp_data  = '0;
        bank_we        = '0;
        push           = 1'b0;
        clear          = 1'b0;
        mem_en         = 1'b0;
        mem_we         = 1'b0;
        mem_addr       = st_q.addr;
        mem_wdata      = '0;
        case (st_q.phase)
            PH_IDLE: begin
                if (commit) begin
                    if (pq_count != '0) begin
                        st_d.phase = PH_DRAIN;
                        st_d.ent   = '0;
                        st_d.bidx  = '0;
                    end
                end else if (req_valid) begin
                    st_d.rsp_valid = 1'b1;
                    if (req_bad) begin
                        st_d.rsp_err = 1'b1;
                    end else if (!req_store) begin
                        if (sp == SP_MEM) begin
                            st_d.rsp_valid = 1'b0;
                            st_d.phase     = PH_READ;
                            st_d.nbytes    = size_bytes(sz);
                            st_d.issued    = '0;
                            st_d.got       = '0;
                            st_d.pend      = 1'b0;
                            st_d.addr      = req_mod;
                            st_d.acc       = '0;
                            st_d.size      = sz;
                            st_d.sext      = req_sext;
                        end else begin
                            st_d.rsp_data = narrow((sp == SP_DREG) ? bank_rdata[0] : bank_rdata[1],
                                                   sz, req_sext);
                        end
                    end else if (sp == SP_MEM) begin
                        if (pq_full) st_d.rsp_err = 1'b1;
                        else         push = 1'b1;
                    end else if (sp == SP_AREG) begin
                        bank_we[1] = 1'b1;
                    end else begin
                        bank_we[0] = 1'b1;
                    end
                end
            end
            PH_READ: begin
                st_d.pend = 1'b0;
                if (st_q.issued != st_q.nbytes) begin
                    mem_en      = 1'b1;
                    mem_addr    = st_q.addr;
                    st_d.addr   = wrap_inc(st_q.addr);
                    st_d.issued = st_q.issued + 3'd1;
                    st_d.pend   = 1'b1;
                end
                if (st_q.pend) begin
                    st_d.acc = {st_q.acc[23:0], mem_rdata};
                    st_d.got = st_q.got + 3'd1;
                    if (st_q.got + 3'd1 == st_q.nbytes) begin
                        st_d.rsp_valid = 1'b1;
                        st_d.rsp_data  = narrow({st_q.acc[23:0], mem_rdata}, st_q.size, st_q.sext);
                        st_d.phase     = PH_IDLE;
                    end
                end
            end
            PH_DRAIN: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = drain_addr;
                mem_wdata = drain_byte;
                if (3'(st_q.bidx) + 3'd1 == pq_n) begin
                    st_d.bidx = '0;
                    if (CNT_W'(st_q.ent) + 1'b1 == pq_count) begin
                        clear      = 1'b1;
                        st_d.ent   = '0;
                        st_d.phase = PH_IDLE;
                    end else begin
                        st_d.ent = st_q.ent + 1'b1;
                    end
                end else begin
                    st_d.bidx = st_q.bidx + 2'd1;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy       = (st_q.phase != PH_IDLE);
    assign rsp_valid  = st_q.rsp_valid;
    assign rsp_data   = st_q.rsp_data;
    assign rsp_err    = st_q.rsp_err;
    assign pend_count = pq_count;
endmodule

// File: rtl/opnd_mover_chk.sv
module opnd_mover_chk #(
    parameter int PEND_DEPTH = 4,
    parameter int CNT_W      = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_store,
    input logic [1:0]       req_size,
    input logic [1:0]       req_space,
    input logic             commit,
    input logic             busy,
    input logic             rsp_valid,
    input logic             rsp_err,
    input logic [CNT_W-1:0] pend_count,
    input logic             mem_en,
    input logic             mem_we
);
    logic taken;
    assign taken = req_valid && !busy && !commit;

    a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        32'(pend_count) <= PEND_DEPTH);

    a_r2_bad_size_err: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && req_size == 2'd3) |=> (rsp_valid && rsp_err));

    a_r8_store_counts: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && req_store && req_space == 2'd2 && req_size != 2'd3 && 32'(pend_count) < PEND_DEPTH)
        |=> (pend_count == $past(pend_count) + 1'b1));

    a_r10_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && req_store && req_space == 2'd2 && req_size != 2'd3 && 32'(pend_count) == PEND_DEPTH)
        |=> (rsp_err && $stable(pend_count)));

    a_r9_write_only_draining: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (busy && mem_en));

    a_r9_drain_empties: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && $past(mem_we)) |-> (pend_count == '0));

    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_en);
endmodule

bind opnd_mover opnd_mover_chk #(.PEND_DEPTH(PEND_DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_store  (req_store),
    .req_size   (req_size),
    .req_space  (req_space),
    .commit     (commit),
    .busy       (busy),
    .rsp_valid  (rsp_valid),
    .rsp_err    (rsp_err),
    .pend_count (pend_count),
    .mem_en     (mem_en),
    .mem_we     (mem_we)
);

// File: tb/opnd_mover_tb.sv
module opnd_mover_tb;
    localparam int MEM   = 1000;
    localparam int DEPTH = 4;
    localparam int AW    = $clog2(MEM);
    localparam int CW    = $clog2(DEPTH + 1);

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 0, req_store = 0, req_sext = 0, commit = 0;
    logic [1:0] req_size = 0, req_space = 0;
    logic [2:0] req_reg = 0;
    logic [31:0] req_addr = 0, req_wdata = 0;
    logic busy, rsp_valid, rsp_err, mem_en, mem_we;
    logic [31:0] rsp_data;
    logic [CW-1:0] pend_count;
    logic [AW-1:0] mem_addr;
    logic [7:0] mem_wdata, mem_rdata;

    always #4 clk = ~clk;

    opnd_mover #(.MEM_BYTES(MEM), .PEND_DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
        .req_size(req_size), .req_sext(req_sext), .req_space(req_space), .req_reg(req_reg),
        .req_addr(req_addr), .req_wdata(req_wdata), .commit(commit), .busy(busy),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err), .pend_count(pend_count),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    // RAM model and independent reference state
    logic [7:0]  ram [MEM];
    logic [7:0]  ref_mem [MEM];
    logic [31:0] dref [8];
    logic [31:0] aref [8];
    int          p_addr[$], p_n[$];
    logic [31:0] p_val[$];
    logic [31:0] exp_data[$];
    logic        exp_err[$];
    string       exp_tag[$];
    int total = 0, fails = 0, writes = 0;
    bit done = 0;

    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) ram[mem_addr] <= mem_wdata;
            else        mem_rdata <= ram[mem_addr];
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on every response
    always @(negedge clk) begin
        if (mem_we) writes++;
        if (rst_n && rsp_valid) begin
            if (exp_data.size() == 0) begin
                chk("unexpected response", 32'd1, 32'd0);
            end else begin
                string t;
                logic [31:0] d;
                logic e;
                t = exp_tag.pop_front();
                d = exp_data.pop_front();
                e = exp_err.pop_front();
                chk({t, " data"}, rsp_data, d);
                chk({t, " err"}, 32'(rsp_err), 32'(e));
            end
        end
    end

    function automatic int nbytes(int s);
        return (s == 0) ? 1 : (s == 1) ? 2 : 4;
    endfunction

    function automatic logic [31:0] msk(int s);
        return (s == 0) ? 32'hFF : (s == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
    endfunction

    function automatic logic [31:0] shape(logic [31:0] v, int s, bit sx);
        logic [31:0] r;
        r = v & msk(s);
        if (sx && s == 0 && r[7])  r = r | 32'hFFFF_FF00;
        if (sx && s == 1 && r[15]) r = r | 32'hFFFF_0000;
        return r;
    endfunction

    // driver: computes the expected response, then drives the request
    task automatic op(string tag, bit st, int s, bit sx, int spc, int r, logic [31:0] a, logic [31:0] w);
        logic [31:0] d = 0;
        logic e = 0;
        if (s == 3 || spc == 3) e = 1;
        else if (!st) begin
            if (spc == 2) begin
                for (int k = 0; k < nbytes(s); k++) d = (d << 8) | 32'(ref_mem[(a % MEM + k) % MEM]);
                d = shape(d, s, sx);
            end else d = shape(spc == 0 ? dref[r] : aref[r], s, sx);
        end else if (spc == 2) begin
            if (p_n.size() == DEPTH) e = 1;
            else begin
                p_addr.push_back(int'(a % MEM));
                p_n.push_back(nbytes(s));
                p_val.push_back(w & msk(s));
            end
        end else if (spc == 0) dref[r] = (dref[r] & ~msk(s)) | (w & msk(s));
        else                   aref[r] = (aref[r] & ~msk(s)) | (w & msk(s));
        exp_tag.push_back(tag);
        exp_data.push_back(d);
        exp_err.push_back(e);
        @(negedge clk);
        req_valid = 1; req_store = st; req_size = 2'(s); req_sext = sx;
        req_space = 2'(spc); req_reg = 3'(r); req_addr = a; req_wdata = w;
        @(negedge clk);
        req_valid = 0;
        while (busy) @(negedge clk);
    endtask

    task automatic do_commit();
        @(negedge clk);
        commit = 1;
        @(negedge clk);
        commit = 0;
        while (busy) @(negedge clk);
        while (p_n.size() > 0) begin
            int a, n;
            logic [31:0] v;
            a = p_addr.pop_front(); n = p_n.pop_front(); v = p_val.pop_front();
            for (int k = 0; k < n; k++) ref_mem[(a + k) % MEM] = 8'(v >> (8 * (n - 1 - k)));
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: actual hung expected finished");
            finish_run();
        end
    end

    initial begin
        int w0;
        int mism;
        for (int i = 0; i < MEM; i++) begin
            ram[i] = 8'(i * 37 + 5);
            ref_mem[i] = ram[i];
        end
        for (int i = 0; i < 8; i++) begin dref[i] = 0; aref[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", 32'(busy), 0);
        chk("R1 rsp_valid", 32'(rsp_valid), 0);
        chk("R1 pend_count", 32'(pend_count), 0);
        op("R1 data reg zero", 0, 2, 0, 0, 3, 0, 0);
        op("R1 addr reg zero", 0, 2, 0, 1, 6, 0, 0);
        // R5 register merges
        op("R5 long store", 1, 2, 0, 0, 2, 0, 32'h8899_AABB);
        op("R5 long readback", 0, 2, 0, 0, 2, 0, 0);
        op("R5 byte store", 1, 0, 0, 0, 2, 0, 32'h1122_3344);
        op("R5 after byte", 0, 2, 0, 0, 2, 0, 0);
        op("R5 word store", 1, 1, 0, 0, 2, 0, 32'hCAFE_F788);
        op("R5 after word", 0, 2, 0, 0, 2, 0, 0);
        // R3 / R4 narrowing and sign extension
        op("R3 byte zext", 0, 0, 0, 0, 2, 0, 0);
        op("R4 byte sext", 0, 0, 1, 0, 2, 0, 0);
        op("R3 word zext", 0, 1, 0, 0, 2, 0, 0);
        op("R4 word sext", 0, 1, 1, 0, 2, 0, 0);
        op("R4 long sext unchanged", 0, 2, 1, 0, 2, 0, 0);
        op("R5 addr bank store", 1, 2, 0, 1, 5, 0, 32'h1234_7F01);
        op("R4 positive word sext", 0, 1, 1, 1, 5, 0, 0);
        op("R4 positive byte sext", 0, 0, 1, 1, 5, 0, 0);
        // R2 invalid codes
        op("R2 bad size store", 1, 3, 0, 0, 2, 0, 32'hFFFF_FFFF);
        op("R2 bad space store", 1, 2, 0, 3, 2, 0, 32'h0);
        op("R2 reg untouched", 0, 2, 0, 0, 2, 0, 0);
        op("R2 bad size mem store", 1, 3, 0, 2, 0, 40, 32'h5);
        chk("R2 no pending", 32'(pend_count), 0);
        // R6 / R7 memory fetch
        op("R6 long big-endian", 0, 2, 0, 2, 0, 10, 0);
        op("R6 word", 0, 1, 0, 2, 0, 100, 0);
        op("R4 mem byte sext", 0, 0, 1, 2, 0, 3, 0);
        op("R7 word modulo", 0, 1, 0, 2, 0, 2000, 0);
        op("R7 long wraps", 0, 2, 0, 2, 0, 998, 0);
        op("R7 large address", 0, 2, 0, 2, 0, 32'hFFFF_FFF0, 0);
        // R8 deferred stores
        w0 = writes;
        op("R8 store long", 1, 2, 0, 2, 0, 20, 32'h0102_0304);
        op("R8 store word wrap", 1, 1, 0, 2, 0, 999, 32'h7777_ABCD);
        op("R8 store byte mod", 1, 0, 0, 2, 0, 1003, 32'h1234_565A);
        chk("R8 count three", 32'(pend_count), 3);
        op("R8 fetch sees old", 0, 2, 0, 2, 0, 20, 0);
        chk("R8 no memory writes", 32'(writes - w0), 0);
        op("R9 later store same byte", 1, 0, 0, 2, 0, 20, 32'h0000_00EE);
        op("R10 store when full", 1, 2, 0, 2, 0, 500, 32'hDEAD_BEEF);
        chk("R10 count held", 32'(pend_count), 4);
        // R9 commit
        do_commit();
        chk("R9 count cleared", 32'(pend_count), 0);
        chk("R9 bytes written", 32'(writes - w0), 8);
        mism = 0;
        for (int i = 0; i < MEM; i++) if (ram[i] !== ref_mem[i]) mism++;
        chk("R9 memory image", 32'(mism), 0);
        op("R9 last store wins", 0, 2, 0, 2, 0, 20, 0);
        op("R9 wrapped word", 0, 1, 0, 2, 0, 999, 0);
        chk("R10 dropped store absent", {ram[500], ram[501], ram[502], ram[503]},
            {ref_mem[500], ref_mem[501], ref_mem[502], ref_mem[503]});
        // R11 empty commit
        w0 = writes;
        @(negedge clk);
        commit = 1;
        @(negedge clk);
        commit = 0;
        chk("R11 not busy", 32'(busy), 0);
        repeat (2) @(negedge clk);
        chk("R11 no writes", 32'(writes - w0), 0);
        repeat (2) @(negedge clk);
        chk("scoreboard drained", 32'(exp_data.size()), 0);
        finish_run();
    end
endmodule